// File: doc/BRIEF.md
# Predicated Contiguous Doubleword Vector Load

This block runs one contiguous vector load of 64-bit unsigned elements under a per-lane predicate. A single-cycle `start` pulse provides a base address, a scalar index counted in 8-byte units, and a predicate mask with one bit per lane. The block then walks the active lanes in ascending order. For each active lane it issues one 64-bit read on a request/response memory port, and it places each returned word into its lane of the destination vector.

Lanes whose predicate bit is clear are never requested from memory, so they can never fault, and they are written as zero. Memory can flag an error on any response. If any active lane's response carries an error, the block reports a fault and the lowest faulting lane, and it suppresses the destination write. The vector length is a synthesis parameter covering 128 to 2048 bits.

Top module: `pred_vload`

## Requirements
- R1: The start address is `base_addr + (index << 3)`, computed modulo 2^64.
- R2: Lane i is read from start address + 8*i, modulo 2^64. Requests for active lanes are issued in ascending lane order, one request per active lane.
- R3: No memory request is ever issued for a lane whose predicate bit is 0. An error can therefore never be attributed to such a lane, even if its address is flagged bad by memory.
- R4: When the destination is written, every lane whose predicate bit is 0 holds all zeros.
- R5: When the destination is written, every active lane holds the 64-bit response data returned for its address, unmodified.
- R6: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address does not change on the next cycle.
- R7: If any active lane's response has `mem_rsp_err` set, then during `done` the `fault` output is 1, `fault_lane` holds the lowest faulting lane index, and `vreg_we` is 0. With no error, `fault` is 0 and `vreg_we` equals `done`.
- R8: `done` is a one-cycle pulse. It appears in the cycle after the last active lane's response, or in the cycle after an accepted `start` whose predicate is all zeros; in the all-zero case no request is issued.
- R9: A `start` pulse that arrives while `busy` is high is ignored and does not alter the load in progress.
- R10: `VL_BITS` must be 128, 256, 512, 1024 or 2048. The lane count is `VL_BITS/64` and `vreg_data` is `VL_BITS` bits wide, with lane i in bits [64i+63:64i].
- R11: After reset, `busy`, `done`, `mem_req_valid`, `vreg_we` and `fault` are all 0. Whenever `busy` is 0, `mem_req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load; accepted only while not busy |
| base_addr | input | 64 | Base byte address |
| index | input | 64 | Scalar index in 8-byte units |
| pred | input | VL_BITS/64 | Per-lane predicate, bit i enables lane i |
| busy | output | 1 | A load is in progress |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Read request byte address |
| mem_rsp_valid | input | 1 | Read response valid, in request order |
| mem_rsp_data | input | 64 | Read response data |
| mem_rsp_err | input | 1 | Read response error flag |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | An active lane returned an error |
| fault_lane | output | log2(VL_BITS/64) | Lowest faulting lane index |
| vreg_we | output | 1 | Destination write enable |
| vreg_data | output | VL_BITS | Assembled destination vector |

## Verification
The bound checker watches several properties on every cycle. It recomputes the start address from the accepted command and checks that each request lands on an active lane at an 8-byte step from it. It also checks that requests hold while stalled, that `done` lasts one cycle, that a fault blocks the write, that inactive lanes read as zero whenever the destination is written, and that no request appears while idle. Some behaviour can only be shown by the bench's scenarios: the exact data per lane, the ascending order and count of requests, the choice of the lowest faulting lane, the timing of `done` against the last response, address wrap-around, and that a start pulse during a busy load is ignored. The bench covers these with directed and seeded random operations against a modelled memory that stalls at random.

// File: rtl/pvl_pkg.sv
package pvl_pkg;
   localparam int unsigned ELEM_W = 64;
   localparam int unsigned ADDR_W = 64;
   localparam int unsigned ELEM_SHIFT = 3;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } pvl_state_e;
endpackage

// File: rtl/pvl_first_set.sv
module pvl_first_set #(
   parameter int unsigned N = 8,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  onehot
);
   always_comb begin
      any = |vec;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
      onehot = vec & (~vec + N'(1));
   end
endmodule

// File: rtl/pvl_addr_gen.sv
module pvl_addr_gen
   import pvl_pkg::*;
#(
   parameter int unsigned LANES = 8,
   localparam int unsigned IW = $clog2(LANES)
) (
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [ADDR_W-1:0] index,
   input  logic [ADDR_W-1:0] seg_start,
   input  logic [IW-1:0]     lane,
   output logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] lane_addr
);
   // Both sums wrap modulo 2^64 by width truncation.
   assign start_addr = base_addr + (index << ELEM_SHIFT);
   assign lane_addr  = seg_start + (ADDR_W'(lane) << ELEM_SHIFT);
endmodule

// File: rtl/pred_vload.sv
module pred_vload
   import pvl_pkg::*;
#(
   parameter int unsigned VL_BITS = 512,
   localparam int unsigned LANES = VL_BITS / ELEM_W,
   localparam int unsigned IW = $clog2(LANES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [63:0]        base_addr,
   input  logic [63:0]        index,
   input  logic [LANES-1:0]   pred,
   output logic               busy,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [63:0]        mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [63:0]        mem_rsp_data,
   input  logic               mem_rsp_err,
   output logic               done,
   output logic               fault,
   output logic [IW-1:0]      fault_lane,
   output logic               vreg_we,
   output logic [VL_BITS-1:0] vreg_data
);
   generate
      if (VL_BITS != 128 && VL_BITS != 256 && VL_BITS != 512 &&
          VL_BITS != 1024 && VL_BITS != 2048) begin : g_bad_vl
         $error("pred_vload: VL_BITS must be a power of two from 128 to 2048");
      end
   endgenerate

   pvl_state_e           state_q;
   logic [LANES-1:0]     req_left_q, rsp_left_q;
   logic [ADDR_W-1:0]    seg_start_q;
   logic                 fault_q;
   logic [IW-1:0]        flane_q;

   logic                 req_any, rsp_any;
   logic [IW-1:0]        req_idx, rsp_idx;
   logic [LANES-1:0]     req_oh, rsp_oh;
   logic [ADDR_W-1:0]    start_addr, lane_addr;
   logic                 accept, req_fire, rsp_fire, rsp_last;

   pvl_first_set #(.N(LANES)) i_req_pick (
      .vec(req_left_q), .any(req_any), .idx(req_idx), .onehot(req_oh)
   );

   pvl_first_set #(.N(LANES)) i_rsp_pick (
      .vec(rsp_left_q), .any(rsp_any), .idx(rsp_idx), .onehot(rsp_oh)
   );

   pvl_addr_gen #(.LANES(LANES)) i_addr (
      .base_addr (base_addr),
      .index     (index),
      .seg_start (seg_start_q),
      .lane      (req_idx),
      .start_addr(start_addr),
      .lane_addr (lane_addr)
   );

   assign accept        = start && (state_q == ST_IDLE);
   assign mem_req_valid = (state_q == ST_RUN) && req_any;
   assign mem_req_addr  = lane_addr;
   assign req_fire      = mem_req_valid && mem_req_ready;
   assign rsp_fire      = (state_q == ST_RUN) && rsp_any && mem_rsp_valid;
   assign rsp_last      = rsp_fire && ((rsp_left_q & ~rsp_oh) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         req_left_q  <= '0;
         rsp_left_q  <= '0;
         seg_start_q <= '0;
         fault_q     <= 1'b0;
         flane_q     <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  seg_start_q <= start_addr;
                  req_left_q  <= pred;
                  rsp_left_q  <= pred;
                  fault_q     <= 1'b0;
                  flane_q     <= '0;
                  state_q     <= (pred == '0) ? ST_FIN : ST_RUN;
               end
            end
            ST_RUN: begin
               if (req_fire) req_left_q <= req_left_q & ~req_oh;
               if (rsp_fire) begin
                  rsp_left_q <= rsp_left_q & ~rsp_oh;
                  if (mem_rsp_err && !fault_q) begin
                     fault_q <= 1'b1;
                     flane_q <= rsp_idx;
                  end
               end
               if (rsp_last) state_q <= ST_FIN;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [ELEM_W-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q <= '0;
            end else if (accept) begin
               word_q <= '0;
            end else if (rsp_fire && rsp_oh[g] && !mem_rsp_err) begin
               word_q <= mem_rsp_data;
            end
         end
         assign vreg_data[g*ELEM_W +: ELEM_W] = word_q;
      end
   endgenerate

   assign busy       = (state_q != ST_IDLE);
   assign done       = (state_q == ST_FIN);
   assign fault      = fault_q;
   assign fault_lane = flane_q;
   assign vreg_we    = done && !fault_q;
endmodule

// File: rtl/pred_vload_chk.sv
module pred_vload_chk #(
   parameter int unsigned VL_BITS = 512,
   localparam int unsigned LANES = VL_BITS / 64,
   localparam int unsigned IW = $clog2(LANES)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [63:0]        base_addr,
   input logic [63:0]        index,
   input logic [LANES-1:0]   pred,
   input logic               busy,
   input logic               mem_req_valid,
   input logic               mem_req_ready,
   input logic [63:0]        mem_req_addr,
   input logic               done,
   input logic               fault,
   input logic               vreg_we,
   input logic [VL_BITS-1:0] vreg_data
);
   logic [LANES-1:0]   s_pred;
   logic [63:0]        s_start;
   logic [63:0]        diff;
   logic [63:0]        lane_off;
   logic [VL_BITS-1:0] act_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_pred  <= '0;
         s_start <= '0;
      end else if (start && !busy) begin
         s_pred  <= pred;
         s_start <= base_addr + {index[60:0], 3'b000};
      end
   end

   assign diff     = mem_req_addr - s_start;
   assign lane_off = {3'b000, diff[63:3]};

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         act_mask[i*64 +: 64] = {64{s_pred[i]}};
      end
   end

   // R2 R3: each request is an active lane at an 8-byte step from the start
   a_r3_active_lane_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (diff[2:0] == 3'b000) && (lane_off < 64'(LANES)) &&
                        s_pred[lane_off[IW-1:0]]);

   a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_fault_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> !vreg_we);

   a_r4_inactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
      vreg_we |-> ((vreg_data & ~act_mask) == '0));

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req_valid && !done));
endmodule

bind pred_vload pred_vload_chk #(.VL_BITS(VL_BITS)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .base_addr    (base_addr),
   .index        (index),
   .pred         (pred),
   .busy         (busy),
   .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready),
   .mem_req_addr (mem_req_addr),
   .done         (done),
   .fault        (fault),
   .vreg_we      (vreg_we),
   .vreg_data    (vreg_data)
);

// File: tb/test_pred_vload.sv
`timescale 1ns/1ps
module test_pred_vload;
   localparam int VL = 512;
   localparam int LN = VL / 64;
   localparam int IW = $clog2(LN);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [63:0]   base_addr = '0, index = '0;
   logic [LN-1:0] pred = '0;
   logic          busy, mem_req_valid, mem_req_ready = 1'b0;
   logic [63:0]   mem_req_addr;
   logic          mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
   logic [63:0]   mem_rsp_data = '0;
   logic          done, fault, vreg_we;
   logic [IW-1:0] fault_lane;
   logic [VL-1:0] vreg_data;

   int n_checks = 0, n_fail = 0, cyc = 0, last_rsp_cyc = 0, log_n = 0;
   logic [63:0] bad_a = 64'h1, bad_b = 64'h1;
   logic [63:0] rq[$];
   logic [63:0] req_log[64];
   bit finished = 0;

   always #10 clk = ~clk;  // 50 MHz

   pred_vload #(.VL_BITS(VL)) i_pred_vload (.*);

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [63:0] mem_word(input logic [63:0] a);
      return {a[31:0] ^ 32'hA5C3_0F1E, ~a[63:32] + a[31:0]};
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // memory model: random stall, in-order responses with random latency
   always @(negedge clk) begin
      if (rst_n) begin
         mem_req_ready = ($urandom % 4) != 0;
         if (rq.size() > 0 && ($urandom % 3) != 0) begin
            logic [63:0] a;
            a = rq.pop_front();
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem_word(a);
            mem_rsp_err   = (a == bad_a) || (a == bad_b);
            last_rsp_cyc  = cyc;
         end else begin
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            mem_rsp_data  = '0;
         end
         if (mem_req_valid && mem_req_ready) begin
            rq.push_back(mem_req_addr);
            if (log_n < 64) req_log[log_n] = mem_req_addr;
            log_n++;
         end
      end
   end

   task automatic run_op(input logic [63:0] b, input logic [63:0] x,
                         input logic [LN-1:0] p, input bit mid_start);
      logic [63:0] sa, a;
      bit          efault;
      int          elane, nact, t0, wait_n;
      sa = b + (x << 3);
      efault = 0; elane = 0; nact = 0;
      for (int i = 0; i < LN; i++) begin
         a = sa + 64'(i) * 64'd8;
         if (p[i]) begin
            nact++;
            if (!efault && (a == bad_a || a == bad_b)) begin
               efault = 1; elane = i;
            end
         end
      end
      log_n = 0;
      @(negedge clk);
      base_addr = b; index = x; pred = p; start = 1'b1; t0 = cyc;
      @(negedge clk);
      start = 1'b0;
      if (mid_start) begin
         check(busy == 1'b1, "R9 busy before stray start", 64'(busy), 64'd1);
         base_addr = ~b; index = x + 64'd5; pred = ~p; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait_n = 0;
      while (!done && wait_n < 2000) begin
         @(negedge clk);
         wait_n++;
      end
      check(done == 1'b1, "R8 done arrives", 64'(done), 64'd1);
      if (p == '0)
         check(cyc == t0 + 1, "R8 done one cycle after empty start", 64'(cyc), 64'(t0 + 1));
      else
         check(cyc == last_rsp_cyc + 1, "R8 done after last response", 64'(cyc),
               64'(last_rsp_cyc + 1));
      check(log_n == nact, "R3 request count equals active lanes", 64'(log_n), 64'(nact));
      begin
         int k = 0;
         for (int i = 0; i < LN; i++) begin
            if (p[i] && k < log_n && k < 64) begin
               a = sa + 64'(i) * 64'd8;
               check(req_log[k] == a, "R1 R2 lane address and order", req_log[k], a);
               k++;
            end
         end
      end
      check(fault == efault, "R7 fault flag", 64'(fault), 64'(efault));
      check(vreg_we == !efault, "R7 write enable", 64'(vreg_we), 64'(!efault));
      if (efault)
         check(fault_lane == IW'(elane), "R7 lowest faulting lane", 64'(fault_lane), 64'(elane));
      else begin
         for (int i = 0; i < LN; i++) begin
            a = sa + 64'(i) * 64'd8;
            if (p[i])
               check(vreg_data[i*64 +: 64] == mem_word(a), "R5 active lane data",
                     vreg_data[i*64 +: 64], mem_word(a));
            else
               check(vreg_data[i*64 +: 64] == '0, "R4 inactive lane zero",
                     vreg_data[i*64 +: 64], 64'd0);
         end
      end
      @(negedge clk);
      check(done == 1'b0, "R8 done lasts one cycle", 64'(done), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      check(busy == 0 && done == 0 && mem_req_valid == 0 && vreg_we == 0 && fault == 0,
            "R11 reset state", {59'd0, busy, done, mem_req_valid, vreg_we, fault}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check($bits(vreg_data) == LN * 64, "R10 vector width", 64'($bits(vreg_data)), 64'(LN * 64));
      check(mem_req_valid == 1'b0, "R11 no request while idle", 64'(mem_req_valid), 64'd0);

      run_op(64'h0000_1000, 64'd4, '1, 0);                  // all lanes
      run_op(64'h0000_2000, 64'd0, '0, 0);                  // empty predicate
      bad_a = 64'h3008;                                     // lane 1, inactive
      run_op(64'h0000_3000, 64'd0, LN'(8'b1010_0101), 0);   // R3: no fault
      bad_a = 64'h4028; bad_b = 64'h4010;                   // lanes 5 and 2
      run_op(64'h0000_4000, 64'd0, '1, 0);                  // R7: lowest is 2
      bad_a = 64'h1; bad_b = 64'h1;
      run_op(64'hFFFF_FFFF_FFFF_FFF0, 64'd1, '1, 0);        // R1 R2 wrap
      run_op(64'h0000_5000, 64'h1FFF_FFFF_FFFF_FFFF, '1, 0); // index shift wraps
      run_op(64'h0000_6000, 64'd3, LN'(8'b0110_1001), 1);   // R9 stray start
      run_op(64'h0000_7000, 64'd0, LN'(1) << (LN - 1), 0);  // only top lane

      for (int n = 0; n < 40; n++) begin
         logic [63:0] b, x;
         logic [LN-1:0] p;
         b = {$urandom, $urandom} & ~64'h7;
         x = 64'($urandom % 4096);
         p = LN'($urandom);
         bad_a = (($urandom % 2) == 0) ? b + (x << 3) + 64'(($urandom % LN) * 8) : 64'h1;
         bad_b = 64'h1;
         run_op(b, x, p, ($urandom % 4) == 0 && p != '0);
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule